// File: doc/BRIEF.md
# Two-Class Interrupt Request Controller

This block gathers up to 32 level-sensitive interrupt lines and turns them into two request pins for a processor. One pin is for the normal class and one is for the fast class. Software sets three things per source: an enable bit, a class bit and a force bit. The force bit lets software raise a request with no hardware event. Read-only views show three things: the raw requesting sources, the enabled requests split by class, and the winning source number in each class.

Hardware lines are captured in one register stage, then masked and steered. A fast-class request always wins: while any enabled fast request exists, the normal pin stays low. Within a class, the lowest-numbered source wins. The winner of the class currently presented also appears on dedicated pins.

The register port is a plain control interface with a write strobe and a combinational read. It carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_class_ctrl`

## Requirements
- R1: After reset, the enable, class and force words read as zero, and all four request outputs are low.
- R2: A source whose enable bit (word 0) is clear contributes to no class pending word, to no request pin and to no source number.
- R3: An enabled, requesting source appears in the fast pending word (word 5) when its class bit (word 1) is 1, and in the normal pending word (word 4) when that bit is 0.
- R4: `irq_fast_o` is high exactly when the fast pending word is non-zero. `irq_norm_o` is high exactly when the normal pending word is non-zero and the fast pending word is zero.
- R5: The request of a source is its sampled line ORed with its force bit (word 2). A force bit keeps its value until software writes word 2 again.
- R6: The raw pending word (word 3) is the sampled lines ORed with the force bits, whatever the enable and class settings.
- R7: Word 6 reports the lowest-numbered pending source of each class. The normal index is in bits 4:0 and its valid flag is bit 7. The fast index is in bits 12:8 and its valid flag is bit 15. An index is 0 when its flag is clear.
- R8: `act_valid_o` is high when either request pin is high. `act_id_o` then carries the fast winner if one exists, otherwise the normal winner.
- R9: A change on `irq_src_i` reaches the registers and outputs after exactly one rising clock edge, and no earlier.
- R10: Writes to word 3 or above leave every register unchanged. Reads of word 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Level interrupt lines, one per source |
| reg_wr_i | input | 1 | Write strobe for the register word at reg_addr_i |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_fast_o | output | 1 | Fast-class request to the processor |
| irq_norm_o | output | 1 | Normal-class request to the processor |
| act_valid_o | output | 1 | A request is being presented |
| act_id_o | output | 5 | Number of the presented source |

## Verification
Some properties are checked on every cycle by the assertions:
- the normal pin never rises alongside the fast pin;
- the presented source is always enabled and belongs to the class of the active pin;
- the valid flag agrees with the request pins;
- force bits change only on a write to their word.

Other behaviour can only be shown by the bench's scenarios: lowest-index selection, the exact layout of the number word, the one-edge input latency, and the rejection of writes to read-only or undefined words. The bench compares each of these against values it derives itself.

// File: rtl/irq_class_pkg.sv
package irq_class_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    W_ENABLE = 3'd0,
    W_CLASS  = 3'd1,
    W_FORCE  = 3'd2,
    W_RAW    = 3'd3,
    W_NORM   = 3'd4,
    W_FAST   = 3'd5,
    W_NUMBER = 3'd6,
    W_NONE   = 3'd7
  } word_e;

  localparam int unsigned NUM_NV_BIT  = 7;
  localparam int unsigned NUM_FID_LSB = 8;
  localparam int unsigned NUM_FV_BIT  = 15;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_class_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      cls_o,
  output logic [N-1:0]      frc_o
);
  logic [N-1:0] en_q, cls_q, frc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cls_q <= '0;
      frc_q <= '0;
    end else if (wr_i) begin
      unique case (word_e'(addr_i))
        W_ENABLE: en_q  <= wdata_i;
        W_CLASS:  cls_q <= wdata_i;
        W_FORCE:  frc_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign en_o  = en_q;
  assign cls_o = cls_q;
  assign frc_o = frc_q;
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] cls_i,
  output logic [N-1:0] norm_o,
  output logic [N-1:0] fast_o
);
  for (genvar s = 0; s < N; s++) begin : g_src
    logic live;
    assign live      = raw_i[s] & en_i[s];
    assign fast_o[s] = live & cls_i[s];
    assign norm_o[s] = live & ~cls_i[s];
  end
endmodule

// File: rtl/irq_low_find.sv
module irq_low_find #(
  parameter int unsigned N   = 32,
  localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   vec_i,
  output logic [IDW-1:0] idx_o,
  output logic           found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IDW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_class_ctrl.sv
module irq_class_ctrl
  import irq_class_pkg::*;
#(
  parameter int unsigned N   = 32,
  localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      irq_src_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  output logic              irq_fast_o,
  output logic              irq_norm_o,
  output logic              act_valid_o,
  output logic [IDW-1:0]    act_id_o
);
  logic [N-1:0]   src_q, en_q, cls_q, frc_q, raw, norm_pend, fast_pend, num_word;
  logic [IDW-1:0] norm_id, fast_id;
  logic           norm_v, fast_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= irq_src_i;
  end

  irq_cfg_regs #(.N(N)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en_q), .cls_o(cls_q), .frc_o(frc_q)
  );

  assign raw = src_q | frc_q;

  irq_steer #(.N(N)) u_steer (
    .raw_i(raw), .en_i(en_q), .cls_i(cls_q), .norm_o(norm_pend), .fast_o(fast_pend)
  );

  irq_low_find #(.N(N)) u_find_norm (.vec_i(norm_pend), .idx_o(norm_id), .found_o(norm_v));
  irq_low_find #(.N(N)) u_find_fast (.vec_i(fast_pend), .idx_o(fast_id), .found_o(fast_v));

  assign irq_fast_o  = fast_v;
  assign irq_norm_o  = norm_v & ~fast_v;
  assign act_valid_o = fast_v | norm_v;
  assign act_id_o    = fast_v ? fast_id : norm_id;

  always_comb begin
    num_word                   = '0;
    num_word[IDW-1:0]          = norm_id;
    num_word[NUM_NV_BIT]       = norm_v;
    num_word[NUM_FID_LSB+:IDW] = fast_id;
    num_word[NUM_FV_BIT]       = fast_v;
  end

  always_comb begin
    unique case (word_e'(reg_addr_i))
      W_ENABLE: reg_rdata_o = en_q;
      W_CLASS:  reg_rdata_o = cls_q;
      W_FORCE:  reg_rdata_o = frc_q;
      W_RAW:    reg_rdata_o = raw;
      W_NORM:   reg_rdata_o = norm_pend;
      W_FAST:   reg_rdata_o = fast_pend;
      W_NUMBER: reg_rdata_o = num_word;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_class_chk.sv
module irq_class_chk
  import irq_class_pkg::*;
#(
  parameter int unsigned N   = 32,
  localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              irq_fast_o,
  input logic              irq_norm_o,
  input logic              act_valid_o,
  input logic [IDW-1:0]    act_id_o,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      cls_q,
  input logic [N-1:0]      frc_q
);
  a_r4_fast_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_norm_o |-> !irq_fast_o);

  a_r8_valid_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o == (irq_fast_o || irq_norm_o));

  a_r2_id_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> en_q[act_id_o]);

  a_r3_fast_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fast_o |-> cls_q[act_id_o]);

  a_r3_norm_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_norm_o |-> !cls_q[act_id_o]);

  a_r5_force_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == W_FORCE) |=> $stable(frc_q));
endmodule

bind irq_class_ctrl irq_class_chk #(.N(N)) chk_i (
  .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .irq_fast_o, .irq_norm_o,
  .act_valid_o, .act_id_o, .en_q(en_q), .cls_q(cls_q), .frc_q(frc_q)
);

// File: tb/irq_class_ctrl_tb_top.sv
module irq_class_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_fast_o, irq_norm_o, act_valid_o;
  logic [4:0]  act_id_o;

  always #4 clk_i = ~clk_i;

  irq_class_ctrl dut_i (.*);

  typedef struct {
    bit          is_pins;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_pins ? {24'd0, irq_fast_o, irq_norm_o, act_valid_o, act_id_o} : reg_rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic push_now(input bit p, input logic [2:0] a, input logic [31:0] e, input string t);
    item_t it;
    reg_addr_i = a;
    it.is_pins = p; it.exp = e; it.tag = t;
    q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string t);
    @(posedge clk_i); #1;
    push_now(1'b0, a, e, t);
  endtask

  task automatic chk_pins(input bit f, input bit n, input bit v, input logic [4:0] id, input string t);
    @(posedge clk_i); #1;
    push_now(1'b1, 3'd0, {24'd0, f, n, v, id}, t);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk_reg(3'd0, 32'h0, "R1 enable");
    chk_reg(3'd1, 32'h0, "R1 class");
    chk_reg(3'd2, 32'h0, "R1 force");
    chk_pins(0, 0, 0, 5'd0, "R1 pins");
    // R6 / R2: raw visible while masked
    @(posedge clk_i); #1 irq_src_i = 32'h10;
    chk_reg(3'd3, 32'h10, "R6 raw");
    chk_reg(3'd4, 32'h0, "R2 masked normal pend");
    chk_pins(0, 0, 0, 5'd0, "R2 masked pins");
    // R3 / R7 / R8: normal class
    wr(3'd0, 32'h30);
    @(posedge clk_i); #1 irq_src_i = 32'h30;
    chk_reg(3'd4, 32'h30, "R3 normal pend");
    chk_reg(3'd5, 32'h0, "R3 fast pend empty");
    chk_pins(0, 1, 1, 5'd4, "R8 normal winner");
    // R3 / R4: fast class wins
    wr(3'd1, 32'h20);
    chk_reg(3'd5, 32'h20, "R3 fast pend");
    chk_reg(3'd4, 32'h10, "R3 normal remainder");
    chk_pins(1, 0, 1, 5'd5, "R4 fast suppresses normal");
    // R5 force
    @(posedge clk_i); #1 irq_src_i = 32'h0;
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h8000_0001);
    wr(3'd2, 32'h8000_0000);
    chk_reg(3'd3, 32'h8000_0000, "R5 forced raw");
    chk_pins(0, 1, 1, 5'd31, "R5 forced request");
    wr(3'd1, 32'h0);
    chk_reg(3'd2, 32'h8000_0000, "R5 force sticky");
    wr(3'd2, 32'h0);
    chk_pins(0, 0, 0, 5'd0, "R5 force cleared");
    // R7 number word
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_0C00);
    @(posedge clk_i); #1 irq_src_i = 32'h0000_0F00;
    chk_reg(3'd6, 32'h0000_8A88, "R7 number word both");
    chk_pins(1, 0, 1, 5'd10, "R8 fast lowest");
    wr(3'd1, 32'h0);
    chk_reg(3'd6, 32'h0000_0088, "R7 number word normal only");
    // R10 undefined and read-only writes
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    chk_reg(3'd7, 32'h0, "R10 undefined reads zero");
    chk_reg(3'd0, 32'hFFFF_FFFF, "R10 enable untouched");
    chk_reg(3'd1, 32'h0, "R10 class untouched");
    chk_reg(3'd2, 32'h0, "R10 force untouched");
    // R9 latency: before edge old value, after edge new value
    @(posedge clk_i); #1 irq_src_i = 32'h1;
    push_now(1'b1, 3'd0, {24'd0, 1'b0, 1'b1, 1'b1, 5'd8}, "R9 before edge");
    chk_pins(0, 1, 1, 5'd0, "R9 after edge");
    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule